// File: doc/BRIEF.md
# PWM-Synchronous Oversampling Averager

This block sits between a center-aligned PWM timer, a multi-channel ADC and a current-control loop. It follows the up-down PWM counter and issues a fixed number of evenly spaced conversion strobes in every PWM period. The first strobe fires at the counter peak and the rest follow at equal steps around the cycle. It sums the conversion results that come back for each channel. When the counter next reaches its peak, which is the center of the cycle, it publishes the per-channel mean of that period's samples and raises a one-clock ready strobe that the control computation starts from.

The oversampling ratio is selected as a power of two, so a complete window is averaged with a right shift. If conversions go missing and the window closes with fewer samples than the ratio, the block still divides by the number actually collected and flags the result as short. The accumulators reload in the same clock that the result is captured, so a sample that arrives in the peak clock is kept and counted in the new window.

Top module: `pwm_oversample_avg`

## Requirements
- R1: While reset is high, and after it until the first counter peak, `adc_trig`, `avg_valid`, `short_err` and `avg_data` are all zero.
- R2: `osr_sel` 0, 1, 2 and 3 select ratios R = 2, 4, 8 and 16. Between two counter peaks exactly R strobes are issued. A strobe is issued at each position k*floor(2*period/R), k = 0..R-1. The position is period-cnt while the counter counts down and period+cnt while it counts up; the peak is position 0. Each strobe is a one-clock pulse on `adc_trig`, one clock after the counter takes that value.
- R3: For a window with R or more samples, channel c of `avg_data` (bits c*DATA_W and up) equals the sum of that channel's first R samples shifted right by log2(R).
- R4: `avg_valid` is a single-clock pulse one clock after the counter first takes the value `pwm_period`. No result is produced at the first peak after reset.
- R5: If a window closes with n < R samples, `short_err` is 1 with the result and the mean is floor(sum/n), or 0 when n = 0. A full window gives `short_err` = 0.
- R6: Samples beyond the R-th in a window are ignored.
- R7: A sample whose `adc_valid` coincides with the peak clock belongs to the window that opens at that peak.
- R8: The accumulator does not overflow: R = 16 full-scale samples average back to full scale.
- R9: `avg_data` and `short_err` hold their values between result pulses.
- R10: A counter value held for several clocks (prescaled timer) produces no extra strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_cnt | input | CNT_W | Up-down PWM counter value |
| pwm_period | input | CNT_W | Counter peak value |
| osr_sel | input | 2 | Oversampling ratio select (2/4/8/16) |
| adc_valid | input | 1 | Conversion result valid |
| adc_data | input | NCH*DATA_W | Conversion results, channel c at bits c*DATA_W |
| adc_trig | output | 1 | Conversion start strobe |
| avg_valid | output | 1 | One-clock result-ready pulse at the counter peak |
| avg_data | output | NCH*DATA_W | Per-channel window mean |
| short_err | output | 1 | Last result came from fewer than R samples |

## Verification
A sample counter or accumulator that is wrong inside a window stays hidden until that window closes. It then shows at the next `avg_valid`, at most one PWM period later, as a wrong mean or a wrong `short_err`. A strobe threshold or position that has drifted shows within the same period, as an `adc_trig` pulse on the wrong clock or a missing one. A corrupted boundary, such as a lost peak-clock sample or a missed accumulator reload, spoils the mean of the very next result.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    localparam int MAX_LOG = 4;
    localparam int SC_W    = MAX_LOG + 1;

    typedef enum logic [1:0] {
        OSR_X2  = 2'd0,
        OSR_X4  = 2'd1,
        OSR_X8  = 2'd2,
        OSR_X16 = 2'd3
    } osr_e;

    typedef struct packed {
        logic fresh;   // counter took a new value this clock
        logic peak;    // counter just reached the period value
    } phase_evt_t;

    function automatic logic [2:0] osr_shift(input osr_e s);
        return 3'(s) + 3'd1;
    endfunction

    function automatic logic [SC_W-1:0] osr_ratio(input osr_e s);
        return SC_W'(1) << osr_shift(s);
    endfunction

endpackage

// File: rtl/ovs_phase.sv
module ovs_phase #(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CNT_W-1:0]      pwm_cnt,
    input  logic [CNT_W-1:0]      pwm_period,
    output ovs_pkg::phase_evt_t   evt,
    output logic [CNT_W:0]        pos
);
    logic [CNT_W-1:0] prev_q;
    logic             down_q;
    logic             down_now;

    always_comb begin
        if (pwm_cnt == pwm_period)
            down_now = 1'b1;
        else if (pwm_cnt == '0)
            down_now = 1'b0;
        else
            down_now = down_q;
        pos = down_now ? ({1'b0, pwm_period} - {1'b0, pwm_cnt})
                       : ({1'b0, pwm_period} + {1'b0, pwm_cnt});
        evt.fresh = (pwm_cnt != prev_q);
        evt.peak  = evt.fresh && (pwm_cnt == pwm_period);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            down_q <= 1'b0;
        end else begin
            prev_q <= pwm_cnt;
            down_q <= down_now;
        end
    end

    // R4: a peak is one clock wide, the counter must leave it first
    a_r4_peak_single: assert property (@(posedge clk) disable iff (rst)
        evt.peak |=> !evt.peak);

endmodule

// File: rtl/ovs_trig.sv
module ovs_trig #(
    parameter int CNT_W = 16,
    parameter int SC_W  = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  ovs_pkg::phase_evt_t   evt,
    input  logic [CNT_W:0]        pos,
    input  logic [CNT_W-1:0]      pwm_period,
    input  logic [2:0]            shift,
    input  logic [SC_W-1:0]       ratio,
    output logic                  trig
);
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   step;
    logic [CNT_W:0]   next_q;
    logic [SC_W-1:0]  idx_q;
    logic             live_q;
    logic             hit;

    always_comb begin
        span = {pwm_period, 1'b0};
        step = span >> shift;
        hit  = live_q && !evt.peak && evt.fresh &&
               (idx_q < ratio) && (pos == next_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig   <= 1'b0;
            live_q <= 1'b0;
            idx_q  <= '0;
            next_q <= '0;
        end else if (evt.peak) begin
            trig   <= 1'b1;
            live_q <= 1'b1;
            idx_q  <= SC_W'(1);
            next_q <= step;
        end else if (hit) begin
            trig   <= 1'b1;
            idx_q  <= idx_q + SC_W'(1);
            next_q <= next_q + step;
        end else begin
            trig   <= 1'b0;
        end
    end

    // R2: every window that closes has issued exactly ratio strobes
    a_r2_trig_per_window: assert property (@(posedge clk) disable iff (rst)
        (evt.peak && live_q) |-> (idx_q == ratio));

    // R10: a strobe only follows a clock in which the counter moved
    a_r10_trig_needs_move: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(evt.fresh));

endmodule

// File: rtl/ovs_chan.sv
module ovs_chan #(
    parameter int DATA_W = 12,
    parameter int ACC_W  = 16,
    parameter int SC_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              publish,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    input  logic [SC_W-1:0]   n_got,
    input  logic              full,
    input  logic [2:0]        shift,
    output logic [DATA_W-1:0] avg_q
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] q;

    always_comb begin
        if (full)
            q = acc_q >> shift;
        else if (n_got == '0)
            q = '0;
        else
            q = acc_q / ACC_W'(n_got);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            avg_q <= '0;
        end else begin
            if (publish)
                avg_q <= q[DATA_W-1:0];
            if (restart)
                acc_q <= take ? ACC_W'(din) : '0;
            else if (take)
                acc_q <= acc_q + ACC_W'(din);
        end
    end

    // R8: adding a sample never wraps the sum
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (take && !restart) |=> (acc_q >= $past(acc_q)));

    // R3: a published mean never exceeds the sample range
    a_r3_mean_fits: assert property (@(posedge clk) disable iff (rst)
        publish |-> ((q >> DATA_W) == '0));

endmodule

// File: rtl/pwm_oversample_avg.sv
module pwm_oversample_avg #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 12,
    parameter int NCH    = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-1:0]        pwm_cnt,
    input  logic [CNT_W-1:0]        pwm_period,
    input  logic [1:0]              osr_sel,
    input  logic                    adc_valid,
    input  logic [NCH*DATA_W-1:0]   adc_data,
    output logic                    adc_trig,
    output logic                    avg_valid,
    output logic [NCH*DATA_W-1:0]   avg_data,
    output logic                    short_err
);
    import ovs_pkg::*;

    localparam int ACC_W = DATA_W + MAX_LOG;

    phase_evt_t       evt;
    logic [CNT_W:0]   pos;
    osr_e             osr;
    logic [2:0]       shift;
    logic [SC_W-1:0]  ratio;
    logic [SC_W-1:0]  count_q;
    logic             armed_q;
    logic             take;
    logic             full;
    logic             publish;

    always_comb begin
        osr     = osr_e'(osr_sel);
        shift   = osr_shift(osr);
        ratio   = osr_ratio(osr);
        take    = adc_valid && (evt.peak || (count_q < ratio));
        full    = (count_q == ratio);
        publish = evt.peak && armed_q;
    end

    ovs_phase #(.CNT_W(CNT_W)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .pwm_cnt    (pwm_cnt),
        .pwm_period (pwm_period),
        .evt        (evt),
        .pos        (pos)
    );

    ovs_trig #(.CNT_W(CNT_W), .SC_W(SC_W)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .pos        (pos),
        .pwm_period (pwm_period),
        .shift      (shift),
        .ratio      (ratio),
        .trig       (adc_trig)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ovs_chan #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SC_W(SC_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .restart (evt.peak),
            .publish (publish),
            .take    (take),
            .din     (adc_data[c*DATA_W +: DATA_W]),
            .n_got   (count_q),
            .full    (full),
            .shift   (shift),
            .avg_q   (avg_data[c*DATA_W +: DATA_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            armed_q   <= 1'b0;
            avg_valid <= 1'b0;
            short_err <= 1'b0;
        end else begin
            armed_q   <= armed_q | evt.peak;
            avg_valid <= publish;
            if (publish)
                short_err <= !full;
            if (evt.peak)
                count_q <= take ? SC_W'(1) : '0;
            else if (take)
                count_q <= count_q + SC_W'(1);
        end
    end

    // R4: an armed peak yields a result on the next clock
    a_r4_valid_after_peak: assert property (@(posedge clk) disable iff (rst)
        publish |=> avg_valid);

    // R4: result strobe is one clock wide
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        avg_valid |=> !avg_valid);

    // R6: the window never counts past the ratio
    a_r6_count_cap: assert property (@(posedge clk) disable iff (rst)
        count_q <= ratio);

    // R9: outputs only move together with the result strobe
    a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
        !avg_valid |-> ($stable(avg_data) && $stable(short_err)));

endmodule

// File: tb/sim_pwm_oversample_avg.sv
`timescale 1ns/1ps
module sim_pwm_oversample_avg;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 12;
    localparam int NCH    = 3;
    localparam int LAT    = 3;
    localparam int DMAX   = (1 << DATA_W) - 1;

    logic                  clk = 1'b0;
    logic                  rst;
    logic [CNT_W-1:0]      pwm_cnt;
    logic [CNT_W-1:0]      pwm_period;
    logic [1:0]            osr_sel;
    logic                  adc_valid;
    logic [NCH*DATA_W-1:0] adc_data;
    logic                  adc_trig;
    logic                  avg_valid;
    logic [NCH*DATA_W-1:0] avg_data;
    logic                  short_err;

    pwm_oversample_avg #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NCH(NCH)) u0 (
        .clk(clk), .rst(rst), .pwm_cnt(pwm_cnt), .pwm_period(pwm_period),
        .osr_sel(osr_sel), .adc_valid(adc_valid), .adc_data(adc_data),
        .adc_trig(adc_trig), .avg_valid(avg_valid), .avg_data(avg_data),
        .short_err(short_err)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model state
    int P, presc, hold, R, lg, step, cnt_b;
    bit up, armed_b, started_b;
    int win_sum [NCH];
    int win_n;
    bit exp_trig, exp_valid, exp_err;
    int exp_avg [NCH];
    string exp_tag, tag_run;
    logic [NCH*DATA_W-1:0] last_data;
    bit last_err;
    int drop_pct, extra_pct;
    bit full_scale, force_peak;
    logic [LAT-1:0] pipe;

    function automatic int mean_of(int s, int n, int r, int l);
        if (n == r) return s >> l;
        if (n == 0) return 0;
        return s / n;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cfg(int dp, int ep, bit fs, bit fp, string tg);
        drop_pct = dp; extra_pct = ep; full_scale = fs; force_peak = fp; tag_run = tg;
    endtask

    task automatic do_reset(int per, int pre, int sel);
        rst = 1'b1; pwm_period = CNT_W'(per); osr_sel = 2'(sel);
        pwm_cnt = '0; adc_valid = 1'b0; adc_data = '0;
        P = per; presc = pre; hold = pre; lg = sel + 1; R = 1 << lg; step = (2 * per) / R;
        cnt_b = 0; up = 1; armed_b = 0; started_b = 0; win_n = 0;
        for (int c = 0; c < NCH; c++) win_sum[c] = 0;
        exp_trig = 0; exp_valid = 0; pipe = '0; last_data = '0; last_err = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(adc_trig == 1'b0, "R1", "adc_trig in reset", int'(adc_trig), 0);
        check(avg_valid == 1'b0, "R1", "avg_valid in reset", int'(avg_valid), 0);
        check(avg_data == '0, "R1", "avg_data in reset", int'(avg_data[31:0]), 0);
        check(short_err == 1'b0, "R1", "short_err in reset", int'(short_err), 0);
        rst = 1'b0;
    endtask

    task automatic tick();
        bit new_v, pk, dlv;
        int nx, pos_b, d;
        logic [NCH*DATA_W-1:0] nd;
        string ttag;
        @(negedge clk);
        // outputs produced by the previous edge
        if (exp_trig || adc_trig) begin
            ttag = !started_b ? "R1" : (presc > 1 ? "R10" : "R2");
            check(adc_trig == exp_trig, ttag, "adc_trig", int'(adc_trig), int'(exp_trig));
        end
        if (exp_valid) begin
            check(avg_valid == 1'b1, "R4", "avg_valid at peak", int'(avg_valid), 1);
            for (int c = 0; c < NCH; c++)
                check(int'(avg_data[c*DATA_W +: DATA_W]) == exp_avg[c], exp_tag, "channel mean",
                      int'(avg_data[c*DATA_W +: DATA_W]), exp_avg[c]);
            check(short_err == exp_err, "R5", "short_err", int'(short_err), int'(exp_err));
            last_data = avg_data; last_err = short_err;
        end else begin
            check(avg_valid == 1'b0, "R4", "avg_valid off peak", int'(avg_valid), 0);
            check(avg_data == last_data && short_err == last_err, "R9", "held result",
                  int'(avg_data[31:0]), int'(last_data[31:0]));
        end
        // ADC model
        dlv = pipe[0];
        pipe = pipe >> 1;
        if (adc_trig && (($urandom % 100) >= 32'(drop_pct))) pipe[LAT-1] = 1'b1;
        if (!dlv && extra_pct > 0 && (($urandom % 100) < 32'(extra_pct))) dlv = 1;
        // counter model
        new_v = 0; nx = cnt_b;
        if (hold > 1) hold--;
        else begin
            hold = presc; new_v = 1;
            if (up) begin
                if (cnt_b == P) begin up = 0; nx = cnt_b - 1; end
                else nx = cnt_b + 1;
            end else begin
                if (cnt_b == 0) begin up = 1; nx = 1; end
                else nx = cnt_b - 1;
            end
        end
        pk = new_v && (nx == P);
        if (pk && force_peak) dlv = 1;
        nd = '0;
        for (int c = 0; c < NCH; c++) begin
            d = full_scale ? DMAX : int'($urandom % (DMAX + 1));
            nd[c*DATA_W +: DATA_W] = DATA_W'(d);
        end
        // window model
        exp_valid = 0; exp_trig = 0;
        if (pk) begin
            if (armed_b) begin
                exp_valid = 1;
                for (int c = 0; c < NCH; c++) exp_avg[c] = mean_of(win_sum[c], win_n, R, lg);
                exp_err = (win_n < R);
                exp_tag = (win_n < R) ? "R5" : tag_run;
            end
            armed_b = 1; started_b = 1; win_n = 0;
            for (int c = 0; c < NCH; c++) win_sum[c] = 0;
        end
        if (dlv && win_n < R) begin
            for (int c = 0; c < NCH; c++) win_sum[c] += int'(nd[c*DATA_W +: DATA_W]);
            win_n++;
        end
        // expected strobe
        if (new_v) begin
            if (pk) exp_trig = 1;
            else if (started_b) begin
                pos_b = up ? P + nx : P - nx;
                exp_trig = (pos_b % step == 0) && (pos_b / step < R);
            end
        end
        cnt_b = nx; pwm_cnt = CNT_W'(nx); adc_valid = dlv; adc_data = nd;
    endtask

    task automatic run(int windows);
        repeat ((windows + 1) * 2 * P * presc + 4) tick();
    endtask

    initial begin
        void'($urandom(32'h5eed));
        cfg(0, 0, 0, 0, "R3"); do_reset(64, 1, 0);
        // R3 / R2: each ratio, full windows
        for (int s = 0; s < 4; s++) begin
            cfg(0, 0, 0, 0, "R3"); do_reset(64, 1, s); run(3);
        end
        // R10: prescaled counter
        cfg(0, 0, 0, 0, "R10"); do_reset(20, 3, 2); run(3);
        // R5: lost conversions, then none at all
        cfg(35, 0, 0, 0, "R5"); do_reset(64, 1, 2); run(4);
        cfg(100, 0, 0, 0, "R5"); do_reset(64, 1, 1); run(2);
        // R6: surplus samples
        cfg(0, 50, 0, 0, "R6"); do_reset(64, 1, 1); run(3);
        // R7: sample on the peak clock
        cfg(0, 0, 0, 1, "R7"); do_reset(64, 1, 2); run(3);
        // R8: full-scale data at the largest ratio
        cfg(0, 0, 1, 0, "R8"); do_reset(64, 1, 3); run(2);
        // mixed random settings
        for (int i = 0; i < 3; i++) begin
            cfg(10, 10, 0, 0, "R3");
            do_reset(40 + int'($urandom % 50), 1 + int'($urandom % 2), int'($urandom % 4));
            run(3);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule